// File: doc/BRIEF.md
# Fetch-gated SPI port controller

This block sits between a CPU and an SPI master. Access to that master is tied to the code the CPU is running. The block watches the CPU instruction-fetch bus, which carries an address, an instruction flag and a valid strobe, and keeps a single permission bit:

- A qualified instruction fetch from one programmable command address sets the bit.
- Any qualified instruction fetch from RAM clears it.

Trusted ROM code therefore opens the SPI port by jumping through the command address. The port closes again as soon as execution moves into RAM.

Software reaches the block through a small register window with an 8-bit address. The window holds four registers:

- the SPI enable;
- the transfer/ready register;
- the transfer data;
- the command address.

While permission is absent, the three SPI registers read as zero and ignore writes. The command-address register stays reachable at all times. A stub master stands in for the shift engine. It always reports ready, and a transfer request replaces its data byte with the bitwise inverse, which gives a loopback echo.

Top module: `fetch_gated_spi_port`

## Requirements
- R1: After reset, permission is clear. The enable (0x80), transfer/ready (0x81), data (0x82) and command-address (0x83) registers all read 0.
- R2: The command-address register (0x83) reads back exactly the value last written, whether or not permission is held.
- R3: A cycle with fetch_instr and fetch_valid both high and fetch_addr equal to the command address sets permission at the next clock edge. From the following cycle, the transfer/ready register reads 1.
- R4: A cycle with fetch_instr and fetch_valid both high and fetch_addr[31:30] equal to 2'b01 (RAM) clears permission at the next edge. The transfer/ready register then reads 0.
- R5: Cycles with fetch_instr low or fetch_valid low never change permission.
- R6: A qualified fetch from a ROM address other than the current command address leaves permission unchanged. After the command address is moved, a fetch from the old address no longer grants.
- R7: While permission is clear, writes to the enable, transfer and data registers have no effect, and reads of those three registers return 0.
- R8: If a qualified fetch both matches the command address and lies in RAM, permission is cleared.
- R9: With permission held and enable bit 0 set, writing the transfer register with bit 0 set replaces the 8-bit data register with its bitwise inverse; with enable clear, such a write leaves the data unchanged.
- R10: With permission held, the enable register stores bit 0 of a write and reads it back at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_addr | input | 32 | CPU fetch address |
| fetch_instr | input | 1 | Access is an instruction fetch |
| fetch_valid | input | 1 | Fetch bus cycle valid |
| reg_cs | input | 1 | Register window select |
| reg_we | input | 1 | Write strobe (read when low) |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current state |

## Verification
The bench builds the block with its default parameters: a 32-bit fetch address whose top two bits select RAM at 2'b01, a 32-bit register word, and an 8-bit stub data byte. These values let the bench place the command address at 0x0000dead, at 0x0000cafe, or inside RAM at 0x40000100. The last placement drives the set-versus-clear conflict directly. The 8-bit echo width makes the value 0xa7 come back as 0x58.

// File: rtl/fgsp_pkg.sv
package fgsp_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h80;
  localparam logic [REG_AW-1:0] OFS_XFER   = 8'h81;
  localparam logic [REG_AW-1:0] OFS_DATA   = 8'h82;
  localparam logic [REG_AW-1:0] OFS_CMD    = 8'h83;

  typedef struct packed {
    logic set_hit;
    logic clr_hit;
  } grant_evt_t;
endpackage

// File: rtl/fgsp_grant.sv
module fgsp_grant #(
  parameter int ADDR_W = 32,
  parameter int TAG_W = 2,
  parameter logic [TAG_W-1:0] RAM_TAG = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_instr,
  input  logic              f_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              grant_q
);
  import fgsp_pkg::*;

  logic       fetch_ok;
  grant_evt_t evt;
  logic       grant_d;
  logic       grant_en;

  always_comb begin
    fetch_ok    = f_instr & f_valid;
    evt.set_hit = fetch_ok & (f_addr == cmd_addr);
    evt.clr_hit = fetch_ok & (f_addr[ADDR_W-1 -: TAG_W] == RAM_TAG);
    grant_en    = evt.set_hit | evt.clr_hit;
    // Clearing wins when both hits occur together.
    grant_d     = evt.clr_hit ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
    end else if (grant_en) begin
      grant_q <= grant_d;
    end
  end
endmodule

// File: rtl/fgsp_regs.sv
module fgsp_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SPI_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       grant,
  input  logic                       cs,
  input  logic                       we,
  input  logic [fgsp_pkg::REG_AW-1:0] addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [ADDR_W-1:0]          cmd_q,
  input  logic                       en_q,
  input  logic                       ready,
  input  logic [SPI_W-1:0]           data_q,
  output logic                       en_we,
  output logic                       en_wbit,
  output logic                       data_we,
  output logic [SPI_W-1:0]           data_w,
  output logic                       start
);
  import fgsp_pkg::*;

  logic              wr;
  logic              cmd_we;
  logic [ADDR_W-1:0] cmd_d;

  always_comb begin
    wr      = cs & we;
    cmd_we  = wr & (addr == OFS_CMD);
    cmd_d   = wdata[ADDR_W-1:0];
    en_we   = wr & grant & (addr == OFS_ENABLE);
    en_wbit = wdata[0];
    data_we = wr & grant & (addr == OFS_DATA);
    data_w  = wdata[SPI_W-1:0];
    start   = wr & grant & (addr == OFS_XFER) & wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_we) begin
      cmd_q <= cmd_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && !we) begin
      unique case (addr)
        OFS_ENABLE: if (grant) rdata = DATA_W'(en_q);
        OFS_XFER:   if (grant) rdata = DATA_W'(ready);
        OFS_DATA:   if (grant) rdata = DATA_W'(data_q);
        OFS_CMD:    rdata = DATA_W'(cmd_q);
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fgsp_stub_master.sv
module fgsp_stub_master #(
  parameter int SPI_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             en_wbit,
  input  logic             data_we,
  input  logic [SPI_W-1:0] data_w,
  input  logic             start,
  output logic             en_q,
  output logic             ready,
  output logic [SPI_W-1:0] data_q
);
  logic             xfer_go;
  logic             data_en;
  logic [SPI_W-1:0] data_d;

  always_comb begin
    ready   = 1'b1;
    xfer_go = start & en_q & ready;
    data_en = data_we | xfer_go;
    data_d  = xfer_go ? ~data_q : data_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_we) begin
      en_q <= en_wbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/fetch_gated_spi_port.sv
module fetch_gated_spi_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SPI_W = 8,
  parameter int TAG_W = 2,
  parameter logic [TAG_W-1:0] RAM_TAG = 2'b01
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           fetch_addr,
  input  logic                        fetch_instr,
  input  logic                        fetch_valid,
  input  logic                        reg_cs,
  input  logic                        reg_we,
  input  logic [fgsp_pkg::REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic                   grant_q;
  logic [ADDR_W-1:0]      cmd_addr_q;
  logic                   en_q;
  logic                   ready;
  logic [SPI_W-1:0]       spi_data_q;
  logic                   en_we;
  logic                   en_wbit;
  logic                   data_we;
  logic [SPI_W-1:0]       data_w;
  logic                   start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  fgsp_grant #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .RAM_TAG(RAM_TAG)) u_grant (
    .clk(clk), .rst_n(rst_sync_n), .f_addr(fetch_addr), .f_instr(fetch_instr),
    .f_valid(fetch_valid), .cmd_addr(cmd_addr_q), .grant_q(grant_q)
  );

  fgsp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPI_W(SPI_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .grant(grant_q), .cs(reg_cs), .we(reg_we),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata), .cmd_q(cmd_addr_q),
    .en_q(en_q), .ready(ready), .data_q(spi_data_q), .en_we(en_we),
    .en_wbit(en_wbit), .data_we(data_we), .data_w(data_w), .start(start)
  );

  fgsp_stub_master #(.SPI_W(SPI_W)) u_stub (
    .clk(clk), .rst_n(rst_sync_n), .en_we(en_we), .en_wbit(en_wbit),
    .data_we(data_we), .data_w(data_w), .start(start), .en_q(en_q),
    .ready(ready), .data_q(spi_data_q)
  );
endmodule

// File: rtl/fgsp_checker.sv
module fgsp_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SPI_W = 8,
  parameter int TAG_W = 2,
  parameter logic [TAG_W-1:0] RAM_TAG = 2'b01
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           f_addr,
  input logic                        f_instr,
  input logic                        f_valid,
  input logic                        grant,
  input logic [ADDR_W-1:0]           cmd_addr,
  input logic                        cs,
  input logic                        we,
  input logic [fgsp_pkg::REG_AW-1:0] addr,
  input logic [DATA_W-1:0]           rdata,
  input logic [SPI_W-1:0]            spi_data
);
  import fgsp_pkg::*;

  logic in_ram;
  logic spi_reg;
  assign in_ram  = f_addr[ADDR_W-1 -: TAG_W] == RAM_TAG;
  assign spi_reg = (addr == OFS_ENABLE) || (addr == OFS_XFER) || (addr == OFS_DATA);

  AST_SET_ON_CMD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (f_instr && f_valid && f_addr == cmd_addr && !in_ram) |=> grant); // R3
  AST_CLEAR_ON_RAM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (f_instr && f_valid && in_ram) |=> !grant); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (f_instr && f_valid && f_addr == cmd_addr && in_ram) |=> !grant); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_instr && f_valid) |=> $stable(grant)); // R5
  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && cs && !we && spi_reg) |-> rdata == '0); // R7
  AST_BLOCKED_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && cs && we) |=> $stable(spi_data)); // R7
endmodule

bind fetch_gated_spi_port fgsp_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPI_W(SPI_W), .TAG_W(TAG_W), .RAM_TAG(RAM_TAG)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .f_addr(fetch_addr), .f_instr(fetch_instr),
  .f_valid(fetch_valid), .grant(grant_q), .cmd_addr(cmd_addr_q), .cs(reg_cs),
  .we(reg_we), .addr(reg_addr), .rdata(reg_rdata), .spi_data(spi_data_q)
);

// File: tb/sim_fetch_gated_spi_port.sv
module sim_fetch_gated_spi_port;
  localparam logic [7:0] A_EN = 8'h80, A_XF = 8'h81, A_DT = 8'h82, A_CM = 8'h83;

  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_addr;
  logic        fetch_instr;
  logic        fetch_valid;
  logic        reg_cs;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  fetch_gated_spi_port u0 (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_instr(fetch_instr),
    .fetch_valid(fetch_valid), .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08x expected 0x%08x", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
    reg_cs = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] a, input logic ins, input logic val);
    @(negedge clk);
    fetch_addr = a; fetch_instr = ins; fetch_valid = val;
    @(negedge clk);
    fetch_instr = 1'b0; fetch_valid = 1'b0; fetch_addr = 32'h0;
  endtask

  task automatic t_reset;
    rd_check("R1 xfer", A_XF, 32'h0);
    rd_check("R1 enable", A_EN, 32'h0);
    rd_check("R1 data", A_DT, 32'h0);
    rd_check("R1 cmd", A_CM, 32'h0);
  endtask

  task automatic t_blocked_then_grant;
    wr(A_CM, 32'h0000dead);
    rd_check("R2 cmd readback ungranted", A_CM, 32'h0000dead);
    wr(A_EN, 32'h1);
    wr(A_DT, 32'ha7);
    rd_check("R7 blocked read data", A_DT, 32'h0);
    fetch(32'h0000dead, 1'b1, 1'b1);
    rd_check("R3 grant after cmd fetch", A_XF, 32'h1);
    rd_check("R7 enable write ignored", A_EN, 32'h0);
    rd_check("R7 data write ignored", A_DT, 32'h0);
  endtask

  task automatic t_echo;
    wr(A_DT, 32'ha7);
    wr(A_XF, 32'h1);
    rd_check("R9 no echo with enable clear", A_DT, 32'ha7);
    wr(A_EN, 32'h1);
    rd_check("R10 enable readback", A_EN, 32'h1);
    wr(A_XF, 32'h1);
    rd_check("R9 echo inverse", A_DT, 32'h58);
  endtask

  task automatic t_non_fetch;
    fetch(32'h4000dead, 1'b0, 1'b1);
    rd_check("R5 data access ignored", A_XF, 32'h1);
    fetch(32'h4000dead, 1'b1, 1'b0);
    rd_check("R5 invalid fetch ignored", A_XF, 32'h1);
  endtask

  task automatic t_revoke_and_move;
    fetch(32'h4000dead, 1'b1, 1'b1);
    rd_check("R4 revoked by RAM fetch", A_XF, 32'h0);
    rd_check("R7 blocked read after revoke", A_DT, 32'h0);
    wr(A_CM, 32'h0000cafe);
    rd_check("R2 cmd moved", A_CM, 32'h0000cafe);
    fetch(32'h0000dead, 1'b1, 1'b1);
    rd_check("R6 old address no grant", A_XF, 32'h0);
    fetch(32'h0000cafe, 1'b1, 1'b1);
    rd_check("R3 new address grants", A_XF, 32'h1);
    fetch(32'h00001234, 1'b1, 1'b1);
    rd_check("R6 other ROM fetch keeps grant", A_XF, 32'h1);
    rd_check("R9 data kept across revoke", A_DT, 32'h58);
  endtask

  task automatic t_conflict;
    wr(A_CM, 32'h40000100);
    rd_check("R8 still granted before", A_XF, 32'h1);
    fetch(32'h40000100, 1'b1, 1'b1);
    rd_check("R8 clear wins", A_XF, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fetch_addr = '0; fetch_instr = 1'b0; fetch_valid = 1'b0;
    reg_cs = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_blocked_then_grant();
    t_echo();
    t_non_fetch();
    t_revoke_and_move();
    t_conflict();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule